// File: doc/BRIEF.md
# Multi-Channel Successive-Approximation Scan Sequencer

This block is the digital control side of an eight-input, ten-bit successive-approximation converter. Software programs four small control registers through a plain read/write port. It starts work by writing a 1 into the run flag. The block then drives the analog input selector, a track/hold strobe and a ten-bit trial code for an external DAC. It reads back one comparator bit per trial and resolves the code MSB first. Each finished conversion is stored in the result register of its channel.

Four operating patterns exist:
- a single conversion of one input;
- endless conversion of one input;
- one pass over a group of inputs starting at input 0;
- endless passes over such a group, in either of two group tables.

Every conversion costs a fixed number of ticks of a divided conversion clock. An input change adds a fixed settling wait. A single conversion or a single pass can end with a one-cycle interrupt request.

Top module: `adc_scan_seq`

## Requirements
- R1: Register map, 8-bit writes, 16-bit reads. Address 0 is CTL_A with channel [2:0], mode [4:3], trigger-select bit 5 (stored and read back only), run flag bit 6 and clock-select bit 0 in bit 7. Address 1 is CTL_B with group code [1:0], group-table bit 2, narrow-result bit 3 and clock-select bit 1 in bit 4. Address 2 is CTL_C with hold-enable bit 0 and clock-select bit 2 in bit 1. Address 3 holds the interrupt level [2:0]. Addresses 8+n are the result registers of channel n. Unused read bits are 0, and every register resets to 0.
- R2: Writing CTL_A with bit 6 set while idle starts work, and bit 6 then reads 1 while a conversion runs. Mode 0 converts the selected channel once and clears the flag by hardware when done.
- R3: The search is MSB first and uses cmp_in = 1 to mean "input >= dac_code". A wide result is the largest code with that property. It sits in bits [9:0] of its register, and bits [15:10] read 0.
- R4: With the narrow-result bit set, only dac_code bits [9:2] are searched. The stored result is those eight bits in register bits [7:0], with bits [15:8] at 0.
- R5: A single conversion lasts (4 + B) conversion ticks from the start write to completion. B is 33 (wide) or 28 (narrow) with hold enabled, and 59 (wide) or 49 (narrow) without hold.
- R6: The clock divisor is selected by {CTL_C[1], CTL_B[4], CTL_A[7]}. Values 0 to 5 give divisors 1, 2, 3, 4, 6 and 12, and values 6 and 7 give 12. One tick lasts that many clk cycles.
- R7: Mode 1 converts the selected channel again and again, refreshing its result each time, until CTL_A is written with bit 6 clear. That write stops work at once, and the conversion it cuts off never reaches a result register.
- R8: Mode 2 converts channels 0 to 2c+1 once (c = group code), waits the settle interval before each, and then clears the run flag. Channels outside the group keep their results.
- R9: Mode 3 with the group-table bit set repeats passes over channels 0 to c. With that bit clear it repeats over channels 0 to 2c+1. It never clears the flag by itself.
- R10: The 4-tick settle wait runs only when a conversion begins on a channel other than the previous one, or first after a start. A repeated conversion of the same channel takes B ticks.
- R11: irq pulses for one clk cycle at the end of a mode 0 conversion or a mode 2 pass when the interrupt level is nonzero. It never pulses in modes 1 and 3, nor after a stop write.
- R12: A result register changes only in the cycle its conversion completes, directly from the old value to the full new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |
| cmp_in | input | 1 | Comparator bit, 1 when the held input is at or above the trial code |
| mux_sel | output | 3 | Analog input selector |
| dac_code | output | 10 | Trial code for the external DAC |
| sample_hold | output | 1 | High while the input is being tracked before the bit trials |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the block with the default settle interval of four ticks. That keeps every conversion between 32 and 63 ticks, so all six divisors can be reached within the cycle limit, including the slowest setting, divide by 12 without hold. At divide by 1, exact cycle counts for whole sweeps, and the gap between two repeated same-channel conversions, are short enough to measure. This shows that the settle wait is skipped when the channel stays the same. A comparator modelled from per-channel analog values lets the bench reach the extreme codes 0 and 1023 and the truncation of narrow results.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int NCH      = 8;
  localparam int CH_W     = $clog2(NCH);
  localparam int RES_W    = 10;
  localparam int NARROW_W = RES_W - 2;
  localparam int IDX_W    = $clog2(RES_W);
  localparam int CNT_W    = 6;
  localparam int DIV_W    = 4;

  localparam logic [1:0] M_ONCE   = 2'd0;
  localparam logic [1:0] M_REPEAT = 2'd1;
  localparam logic [1:0] M_PASS   = 2'd2;
  localparam logic [1:0] M_LOOP   = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE, ST_SAMPLE, ST_TRIAL, ST_DECIDE
  } seq_st_e;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] group;
    logic       table_b;
    logic       narrow;
    logic       hold_en;
    logic [2:0] clk_sel;
  } scan_cfg_t;

  // Clock divisor for a select code
  function automatic logic [DIV_W-1:0] divisor_of(input logic [2:0] sel);
    case (sel)
      3'd0:    divisor_of = DIV_W'(1);
      3'd1:    divisor_of = DIV_W'(2);
      3'd2:    divisor_of = DIV_W'(3);
      3'd3:    divisor_of = DIV_W'(4);
      3'd4:    divisor_of = DIV_W'(6);
      default: divisor_of = DIV_W'(12);
    endcase
  endfunction

  // Tracking ticks: total budget minus two ticks per resolved bit
  function automatic logic [CNT_W-1:0] track_ticks(input logic narrow, input logic hold_en);
    logic [CNT_W-1:0] budget;
    logic [CNT_W-1:0] bits;
    budget = hold_en ? (narrow ? CNT_W'(28) : CNT_W'(33))
                     : (narrow ? CNT_W'(49) : CNT_W'(59));
    bits   = narrow ? CNT_W'(NARROW_W) : CNT_W'(RES_W);
    track_ticks = budget - (bits << 1);
  endfunction

endpackage

// File: rtl/adc_tick_div.sv
module adc_tick_div
  import adc_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] clk_sel,
  output logic       tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div;

  always_comb begin
    div  = divisor_of(clk_sel);
    tick = run && (cnt_q == div - DIV_W'(1));
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Ticks never arrive back to back unless the divisor is one
  assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > DIV_W'(1)) |=> !tick);

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg
  import adc_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             set_bit,
  input  logic             decide,
  input  logic             cmp,
  input  logic             narrow,
  output logic [RES_W-1:0] code,
  output logic             last,
  output logic [RES_W-1:0] result
);

  logic [RES_W-1:0] code_q, code_d, decided;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    decided = code_q;
    if (decide && !cmp) decided[idx_q] = 1'b0;
    code_d = decided;
    idx_d  = idx_q;
    if (decide) idx_d = idx_q - IDX_W'(1);
    if (set_bit) begin
      if (decide) code_d[idx_q - IDX_W'(1)] = 1'b1;
      else        code_d[idx_q] = 1'b1;
    end
    if (clr) begin
      code_d = '0;
      idx_d  = IDX_W'(RES_W - 1);
    end
    last   = narrow ? (idx_q == IDX_W'(RES_W - NARROW_W)) : (idx_q == '0);
    result = narrow ? {{(RES_W-NARROW_W){1'b0}}, decided[RES_W-1 -: NARROW_W]} : decided;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      idx_q  <= IDX_W'(RES_W - 1);
    end else begin
      code_q <= code_d;
      idx_q  <= idx_d;
    end
  end

  assign code = code_q;

  // A trial step adds at most one set bit to the trial code
  assert_one_trial_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bit && !clr) |=> ($countones(code_q) <= $past($countones(code_q)) + 1));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_scan_pkg::*;
#(
  parameter int SETTLE_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  scan_cfg_t        cfg,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic [2:0]       irq_level,
  input  logic             tick,
  input  logic             sar_last,
  output logic             busy,
  output logic [CH_W-1:0]  chan,
  output logic             tracking,
  output logic             sar_clr,
  output logic             sar_set,
  output logic             sar_dec,
  output logic             res_we,
  output logic             irq,
  output logic [2:0]       clk_sel,
  output logic             narrow
);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CH_W-1:0]  ch_q, ch_d, ch_next, last_ch;
  scan_cfg_t        cfg_q, cfg_d;
  logic             irq_q, irq_d;
  logic [CNT_W-1:0] track_n;

  always_comb begin
    track_n = track_ticks(cfg_q.narrow, cfg_q.hold_en);
    last_ch = (cfg_q.mode == M_LOOP && cfg_q.table_b) ? {1'b0, cfg_q.group}
                                                      : {cfg_q.group, 1'b1};
    ch_next = (ch_q == last_ch) ? '0 : ch_q + CH_W'(1);
    st_d    = st_q;
    cnt_d   = cnt_q;
    ch_d    = ch_q;
    cfg_d   = cfg_q;
    irq_d   = 1'b0;
    sar_clr = 1'b0;
    sar_set = 1'b0;
    sar_dec = 1'b0;
    res_we  = 1'b0;
    if (st_q == ST_IDLE) begin
      if (start_req) begin
        cfg_d   = cfg;
        ch_d    = cfg.mode[1] ? '0 : chan_sel;
        st_d    = ST_SETTLE;
        cnt_d   = '0;
        sar_clr = 1'b1;
      end
    end else if (stop_req) begin
      st_d    = ST_IDLE;
      cnt_d   = '0;
      sar_clr = 1'b1;
    end else if (tick) begin
      case (st_q)
        ST_SETTLE: begin
          if (cnt_q == CNT_W'(SETTLE_TICKS - 1)) begin
            st_d  = ST_SAMPLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_SAMPLE: begin
          if (cnt_q == track_n - CNT_W'(1)) begin
            st_d    = ST_TRIAL;
            cnt_d   = '0;
            sar_set = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_TRIAL: st_d = ST_DECIDE;
        ST_DECIDE: begin
          sar_dec = 1'b1;
          if (!sar_last) begin
            sar_set = 1'b1;
            st_d    = ST_TRIAL;
          end else begin
            res_we  = 1'b1;
            sar_clr = 1'b1;
            cnt_d   = '0;
            case (cfg_q.mode)
              M_ONCE: begin
                st_d  = ST_IDLE;
                irq_d = (irq_level != 3'd0);
              end
              M_REPEAT: st_d = ST_SAMPLE;
              M_PASS: begin
                if (ch_q == last_ch) begin
                  st_d  = ST_IDLE;
                  irq_d = (irq_level != 3'd0);
                end else begin
                  ch_d = ch_next;
                  st_d = ST_SETTLE;
                end
              end
              default: begin
                ch_d = ch_next;
                st_d = (ch_next == ch_q) ? ST_SAMPLE : ST_SETTLE;
              end
            endcase
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ch_q  <= '0;
      cfg_q <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ch_q  <= ch_d;
      cfg_q <= cfg_d;
      irq_q <= irq_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign chan     = ch_q;
  assign tracking = (st_q == ST_SAMPLE);
  assign irq      = irq_q;
  assign clk_sel  = cfg_q.clk_sel;
  assign narrow   = cfg_q.narrow;

  // The input selector holds still while the input is tracked
  assert_mux_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SAMPLE && $past(st_q) == ST_SAMPLE) |-> $stable(ch_q));

  // Interrupts only follow a finished single conversion or single pass
  assert_irq_terminal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (!busy && !$past(cfg_q.mode[0])));

  // A stop request always lands in idle on the next cycle
  assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && busy) |=> !busy);

endmodule

// File: rtl/adc_regs.sv
module adc_regs
  import adc_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic             busy,
  input  logic             res_we,
  input  logic [CH_W-1:0]  res_ch,
  input  logic [RES_W-1:0] res_val,
  output logic             start_req,
  output logic             stop_req,
  output scan_cfg_t        cfg,
  output logic [CH_W-1:0]  chan_sel,
  output logic [2:0]       irq_level
);

  logic [CH_W-1:0] a_chan;
  logic [1:0]      a_mode;
  logic            a_trig, a_fs0;
  logic [1:0]      b_group;
  logic            b_table, b_narrow, b_fs1;
  logic            c_hold, c_fs2;
  logic [2:0]      lvl_q;
  logic            wr_a, wr_b, wr_c, wr_l;
  logic [RES_W-1:0] res_q [NCH];

  assign wr_a = reg_wr && (reg_addr == 4'd0);
  assign wr_b = reg_wr && (reg_addr == 4'd1);
  assign wr_c = reg_wr && (reg_addr == 4'd2);
  assign wr_l = reg_wr && (reg_addr == 4'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_chan <= '0; a_mode <= '0; a_trig <= 1'b0; a_fs0 <= 1'b0;
    end else if (wr_a) begin
      a_chan <= reg_wdata[2:0];
      a_mode <= reg_wdata[4:3];
      a_trig <= reg_wdata[5];
      a_fs0  <= reg_wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_group <= '0; b_table <= 1'b0; b_narrow <= 1'b0; b_fs1 <= 1'b0;
    end else if (wr_b) begin
      b_group  <= reg_wdata[1:0];
      b_table  <= reg_wdata[2];
      b_narrow <= reg_wdata[3];
      b_fs1    <= reg_wdata[4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_hold <= 1'b0; c_fs2 <= 1'b0;
    end else if (wr_c) begin
      c_hold <= reg_wdata[0];
      c_fs2  <= reg_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lvl_q <= '0;
    else if (wr_l) lvl_q <= reg_wdata[2:0];
  end

  for (genvar gi = 0; gi < NCH; gi++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                res_q[gi] <= '0;
      else if (res_we && res_ch == CH_W'(gi))    res_q[gi] <= res_val;
    end

    // Results move only on their own completion cycle
    assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_we && res_ch == CH_W'(gi)) |=> $stable(res_q[gi]));
  end

  // Control fields as seen by a start: a write to CTL_A takes effect with it
  always_comb begin
    start_req   = wr_a && reg_wdata[6];
    stop_req    = wr_a && !reg_wdata[6];
    chan_sel    = wr_a ? reg_wdata[2:0] : a_chan;
    cfg.mode    = wr_a ? reg_wdata[4:3] : a_mode;
    cfg.clk_sel = {c_fs2, b_fs1, wr_a ? reg_wdata[7] : a_fs0};
    cfg.group   = b_group;
    cfg.table_b = b_table;
    cfg.narrow  = b_narrow;
    cfg.hold_en = c_hold;
    irq_level   = lvl_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[3]) begin
      reg_rdata = {{(16-RES_W){1'b0}}, res_q[reg_addr[2:0]]};
    end else begin
      case (reg_addr[2:0])
        3'd0: reg_rdata = {8'd0, a_fs0, busy, a_trig, a_mode, a_chan};
        3'd1: reg_rdata = {11'd0, b_fs1, b_narrow, b_table, b_group};
        3'd2: reg_rdata = {14'd0, c_fs2, c_hold};
        3'd3: reg_rdata = {13'd0, lvl_q};
        default: reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int SETTLE_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic             cmp_in,
  output logic [CH_W-1:0]  mux_sel,
  output logic [RES_W-1:0] dac_code,
  output logic             sample_hold,
  output logic             irq
);

  logic [1:0]       rst_sync;
  logic             rst_n_s;
  logic             start_req, stop_req, busy, tick;
  logic             sar_clr, sar_set, sar_dec, sar_last, res_we, narrow;
  logic [CH_W-1:0]  chan_sel, chan;
  logic [2:0]       irq_level, clk_sel;
  logic [RES_W-1:0] sar_result;
  scan_cfg_t        cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  adc_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .res_we(res_we), .res_ch(chan), .res_val(sar_result),
    .start_req(start_req), .stop_req(stop_req), .cfg(cfg),
    .chan_sel(chan_sel), .irq_level(irq_level)
  );

  adc_seq_fsm #(.SETTLE_TICKS(SETTLE_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .start_req(start_req), .stop_req(stop_req),
    .cfg(cfg), .chan_sel(chan_sel), .irq_level(irq_level), .tick(tick),
    .sar_last(sar_last), .busy(busy), .chan(chan), .tracking(sample_hold),
    .sar_clr(sar_clr), .sar_set(sar_set), .sar_dec(sar_dec),
    .res_we(res_we), .irq(irq), .clk_sel(clk_sel), .narrow(narrow)
  );

  adc_tick_div u_div (
    .clk(clk), .rst_n(rst_n_s), .run(busy), .clk_sel(clk_sel), .tick(tick)
  );

  adc_sar_reg u_sar (
    .clk(clk), .rst_n(rst_n_s), .clr(sar_clr), .set_bit(sar_set),
    .decide(sar_dec), .cmp(cmp_in), .narrow(narrow), .code(dac_code),
    .last(sar_last), .result(sar_result)
  );

  assign mux_sel = chan;

endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        cmp_in;
  logic [2:0]  mux_sel;
  logic [9:0]  dac_code;
  logic        sample_hold;
  logic        irq;
  logic [9:0]  va [8];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_in(cmp_in),
    .mux_sel(mux_sel), .dac_code(dac_code), .sample_hold(sample_hold), .irq(irq)
  );

  assign cmp_in = (va[mux_sel] >= dac_code);

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // chan, analog value, narrow, hold, clock select, irq level
  localparam int VEC [8][6] = '{
    '{0, 'h2A5, 0, 1, 0, 1},
    '{3, 1023,  0, 1, 1, 3},
    '{5, 0,     1, 1, 2, 0},
    '{7, 'h155, 1, 0, 3, 7},
    '{2, 'h201, 0, 0, 4, 2},
    '{6, 'h0FF, 1, 1, 5, 1},
    '{1, 'h1FF, 0, 1, 7, 1},
    '{4, 3,     1, 0, 6, 0}
  };

  function automatic int divisor(int s);
    case (s)
      0: return 1;  1: return 2;  2: return 3;
      3: return 4;  4: return 6;  default: return 12;
    endcase
  endfunction

  function automatic int budget(int nar, int hold);
    if (hold != 0) return (nar != 0) ? 28 : 33;
    return (nar != 0) ? 49 : 59;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic tick_cycle(inout int irqs);
    @(posedge clk);
    #1 if (irq) irqs++;
  endtask

  // Wait for the run flag to drop; return cycles from start edge and irq pulses
  task automatic wait_idle(output int n, output int irqs);
    n = 0; irqs = 0;
    reg_addr = 4'd0;
    while (n < 20000) begin
      tick_cycle(irqs);
      n++;
      if (reg_rdata[6] == 1'b0) break;
    end
  endtask

  task automatic wait_result(input int ch, input int val, output int n, inout int irqs);
    n = 0;
    reg_addr = 4'(8 + ch);
    while (n < 5000) begin
      tick_cycle(irqs);
      n++;
      if (int'(reg_rdata) == val) break;
    end
  endtask

  initial begin
    int v, n, irqs, expn, expv;
    for (int i = 0; i < 8; i++) va[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // Reset state (R1)
    rd(4'd0, v); chk(v == 0, "R1 reset CTL_A", v, 0);
    rd(4'd9, v); chk(v == 0, "R1 reset result", v, 0);
    chk(irq == 1'b0, "R11 reset irq", int'(irq), 0);

    // Register read-back (R1)
    wr(4'd1, 8'h1F); rd(4'd1, v); chk(v == 'h1F, "R1 CTL_B readback", v, 'h1F);
    wr(4'd2, 8'hFF); rd(4'd2, v); chk(v == 'h3, "R1 CTL_C readback", v, 3);

    // Single conversions across widths, hold and divisors (R2 R3 R4 R5 R6 R11)
    for (int i = 0; i < 8; i++) begin
      int ch, fs;
      ch = VEC[i][0]; fs = VEC[i][4];
      va[ch] = 10'(VEC[i][1]);
      wr(4'd1, {3'b0, 1'(fs >> 1), 1'(VEC[i][2]), 3'b0});
      wr(4'd2, {6'b0, 1'(fs >> 2), 1'(VEC[i][3])});
      wr(4'd3, 8'(VEC[i][5]));
      wr(4'd0, {1'(fs), 1'b1, 1'b0, 2'b00, 3'(ch)});
      wait_idle(n, irqs);
      expn = (4 + budget(VEC[i][2], VEC[i][3])) * divisor(fs);
      chk(n == expn, "R5 R6 conversion cycles", n, expn);
      chk(irqs == ((VEC[i][5] != 0) ? 1 : 0), "R11 single irq", irqs, (VEC[i][5] != 0) ? 1 : 0);
      expv = (VEC[i][2] != 0) ? (VEC[i][1] >> 2) : VEC[i][1];
      rd(4'(8 + ch), v);
      chk(v == expv, "R2 R3 R4 result", v, expv);
    end

    // Repeat on one channel, settle skipped on repeats, stop (R7 R10 R11)
    va[2] = 10'd100;
    wr(4'd1, 8'h00); wr(4'd2, 8'h01); wr(4'd3, 8'h01);
    wr(4'd0, 8'b0100_1010);
    irqs = 0;
    wait_result(2, 100, n, irqs);
    chk(n == 37, "R7 first repeat conversion", n, 37);
    va[2] = 10'd200;
    wait_result(2, 200, n, irqs);
    chk(n == 33, "R10 repeat without settle", n, 33);
    chk(irqs == 0, "R11 no irq in repeat", irqs, 0);
    rd(4'd0, v); chk(v[6] == 1'b1, "R7 still running", v[6], 1);
    wr(4'd0, 8'b0000_1010);
    rd(4'd0, v); chk(v[6] == 1'b0, "R7 stop clears flag", v[6], 0);
    va[2] = 10'd300;
    repeat (100) @(posedge clk);
    #1 rd(4'd10, v); chk(v == 200, "R7 stopped result frozen", v, 200);

    // Abort a single conversion (R7 R11 R12)
    va[5] = 10'd500;
    wr(4'd0, 8'b0100_0101);
    repeat (20) @(posedge clk);
    wr(4'd0, 8'b0000_0101);
    irqs = 0;
    for (int k = 0; k < 100; k++) tick_cycle(irqs);
    chk(irqs == 0, "R11 no irq after stop", irqs, 0);
    rd(4'd13, v); chk(v == 0, "R12 aborted result untouched", v, 0);

    // Single pass over channels 0..3 (R8 R11)
    va[0] = 10'd11; va[1] = 10'd22; va[2] = 10'd33; va[3] = 10'd44; va[4] = 10'd55;
    wr(4'd1, 8'h01);
    wr(4'd0, 8'b0101_0000);
    wait_idle(n, irqs);
    chk(n == 4 * 37, "R8 pass cycles", n, 4 * 37);
    chk(irqs == 1, "R11 pass irq", irqs, 1);
    for (int c = 0; c < 4; c++) begin
      rd(4'(8 + c), v); chk(v == 11 * (c + 1), "R8 pass result", v, 11 * (c + 1));
    end
    rd(4'd12, v); chk(v == 0, "R8 channel outside group", v, 0);

    // Repeating pass, second table, channels 0..2 (R9 R11)
    va[0] = 10'd101; va[1] = 10'd202; va[2] = 10'd303; va[3] = 10'd404;
    wr(4'd1, 8'h06);
    wr(4'd0, 8'b0101_1000);
    irqs = 0;
    for (int k = 0; k < 3 * 37 * 2 + 10; k++) tick_cycle(irqs);
    rd(4'd0, v); chk(v[6] == 1'b1, "R9 loop keeps running", v[6], 1);
    chk(irqs == 0, "R11 no irq in loop", irqs, 0);
    for (int c = 0; c < 3; c++) begin
      rd(4'(8 + c), v); chk(v == 101 * (c + 1), "R9 loop result", v, 101 * (c + 1));
    end
    rd(4'd11, v); chk(v == 44, "R9 channel 3 outside table", v, 44);
    wr(4'd0, 8'b0001_1000);
    rd(4'd0, v); chk(v[6] == 1'b0, "R9 loop stopped", v[6], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule